// File: doc/BRIEF.md
# Halt Mode Power Controller

This block decides when the processor core stops in its low-power halt state and which peripherals keep running while it is stopped. A wait-for-interrupt strobe from the core starts halt only if the core-arm bit of a small mode register is cleared. While halted, the block pulls down the core clock enable and the address strobe gate. It also drops the run enable and the interrupt-request gate of each peripheral whose keep-alive bit is cleared. The peripherals are a serial port and two timer/counters.

When the two counters are chained into one 32-bit counter, the upper counter's keep-alive bit governs both halves. Halt ends one cycle after an external wake event, or after an interrupt request from a peripheral that is still allowed to run. The clock gating cells and the peripherals themselves sit outside this block. The block only produces their enables.

Top module: `halt_power_ctrl`

## Requirements
- R1: After reset the mode register reads 0x0F, the core clock enable and address strobe gate are 1, and all three peripheral run enables are 1.
- R2: A write stores data bits 3:0 in the mode register. Bit 3 is the core arm bit, active low. Bit 2 keeps the serial port running. Bit 1 keeps counter 1 running. Bit 0 keeps counter 0 running. Bits 7:4 always read 0. The new value is readable on the cycle after the write edge.
- R3: A wait-for-interrupt strobe sampled while running, with bit 3 at 0 and no wake source present, drives the core clock enable and the address strobe gate to 0 after that edge.
- R4: A wait-for-interrupt strobe while bit 3 is 1 has no effect: the core clock enable stays 1.
- R5: A wait-for-interrupt strobe in the same cycle as the external wake input or any raw peripheral interrupt request does not start halt.
- R6: While running, every run enable is 1 whatever the register holds, and every raw interrupt request passes to its gated output.
- R7: While halted, the serial port run enable equals bit 2, and its gated interrupt request is 0 when bit 2 is 0.
- R8: While halted with cascade off, the counter 0 run enable equals bit 0, and its gated interrupt request is 0 when bit 0 is 0.
- R9: While halted, the counter 1 run enable equals bit 1. With cascade on, the counter 0 run enable also equals bit 1, whatever bit 0 holds.
- R10: The external wake input while halted restores the core clock enable on the next cycle.
- R11: While halted, a raw interrupt request from a peripheral that is still running ends halt on the next cycle. A request from a stopped peripheral leaves the block halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Mode register write enable |
| cfg_wdata | input | 8 | Mode register write data |
| cfg_rdata | output | 8 | Mode register contents, upper bits zero |
| wfi_strobe | input | 1 | Wait-for-interrupt executed by the core |
| cascade_en | input | 1 | Counters chained into one 32-bit counter |
| wake_ext | input | 1 | External wake event |
| uart_irq_raw | input | 1 | Serial port interrupt request |
| ct0_irq_raw | input | 1 | Counter 0 interrupt request |
| ct1_irq_raw | input | 1 | Counter 1 interrupt request |
| cpu_clk_en | output | 1 | Core clock enable |
| addr_strobe_en | output | 1 | Address strobe gate |
| uart_run | output | 1 | Serial port run enable |
| ct0_run | output | 1 | Counter 0 run enable |
| ct1_run | output | 1 | Counter 1 run enable |
| uart_irq_out | output | 1 | Gated serial port interrupt request |
| ct0_irq_out | output | 1 | Gated counter 0 interrupt request |
| ct1_irq_out | output | 1 | Gated counter 1 interrupt request |

## Verification
The halt state is one register, so entry and exit are due exactly one edge after the strobe or wake that causes them. Register writes are likewise readable one edge later. Run enables and gated interrupt requests are combinational from that state, the register and the inputs, so they are due in the same cycle as the input change. The bench drives every input on the falling edge. It samples register and state results at the next falling edge after the rising edge that updates them, and it samples the combinational gates at the falling edge where their inputs were set.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

    localparam int REG_W      = 8;
    localparam int MODE_W     = 4;
    localparam int NUM_PERIPH = 3;
    localparam int PAD_W      = REG_W - MODE_W;

    localparam int IDX_CT0  = 0;
    localparam int IDX_CT1  = 1;
    localparam int IDX_UART = 2;

    // Field order follows the register bit positions 3..0.
    typedef struct packed {
        logic cpu_keep;   // 0 arms core halt
        logic uart_keep;
        logic ct1_keep;
        logic ct0_keep;
    } mode_t;

    localparam mode_t MODE_RESET = mode_t'(4'hF);

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } hstate_t;

    // Keep-alive bit that governs peripheral idx during halt.
    function automatic logic keep_bit(mode_t m, int idx, logic cascade);
        logic k;
        case (idx)
            IDX_CT0:  k = cascade ? m.ct1_keep : m.ct0_keep;
            IDX_CT1:  k = m.ct1_keep;
            IDX_UART: k = m.uart_keep;
            default:  k = 1'b1;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/hpc_mode_reg.sv
module hpc_mode_reg
    import hpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output mode_t            mode,
    output logic [REG_W-1:0] rdata
);
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[REG_W-1:MODE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_RESET;
        end else if (we) begin
            mode <= mode_t'(wdata[MODE_W-1:0]);
        end
    end

    assign rdata = {{PAD_W{1'b0}}, mode};
endmodule

// File: rtl/hpc_halt_fsm.sv
module hpc_halt_fsm
    import hpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wfi,
    input  logic armed,
    input  logic wake,
    output logic halted
);
    hstate_t state, state_nx;

    always_comb begin
        state_nx = state;
        case (state)
            ST_RUN:  if (wfi && armed && !wake) state_nx = ST_HALT;
            ST_HALT: if (wake)                  state_nx = ST_RUN;
            default:                            state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RUN;
        else     state <= state_nx;
    end

    assign halted = (state == ST_HALT);
endmodule

// File: rtl/hpc_periph_gate.sv
module hpc_periph_gate (
    input  logic halted,
    input  logic keep,
    input  logic irq_raw,
    output logic run,
    output logic irq_out
);
    assign run     = !halted || keep;
    assign irq_out = irq_raw && run;
endmodule

// File: rtl/halt_power_ctrl.sv
module halt_power_ctrl
    import hpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       wfi_strobe,
    input  logic       cascade_en,
    input  logic       wake_ext,
    input  logic       uart_irq_raw,
    input  logic       ct0_irq_raw,
    input  logic       ct1_irq_raw,
    output logic       cpu_clk_en,
    output logic       addr_strobe_en,
    output logic       uart_run,
    output logic       ct0_run,
    output logic       ct1_run,
    output logic       uart_irq_out,
    output logic       ct0_irq_out,
    output logic       ct1_irq_out
);
    mode_t                 mode;
    logic                  halted;
    logic                  wake;
    logic [NUM_PERIPH-1:0] irq_raw_v;
    logic [NUM_PERIPH-1:0] irq_gate_v;
    logic [NUM_PERIPH-1:0] run_v;

    hpc_mode_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .mode  (mode),
        .rdata (cfg_rdata)
    );

    assign irq_raw_v[IDX_CT0]  = ct0_irq_raw;
    assign irq_raw_v[IDX_CT1]  = ct1_irq_raw;
    assign irq_raw_v[IDX_UART] = uart_irq_raw;

    for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_periph
        hpc_periph_gate u_gate (
            .halted  (halted),
            .keep    (keep_bit(mode, g, cascade_en)),
            .irq_raw (irq_raw_v[g]),
            .run     (run_v[g]),
            .irq_out (irq_gate_v[g])
        );
    end

    // While running every gate is open, so any raw request also blocks entry.
    assign wake = wake_ext || (|irq_gate_v);

    hpc_halt_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .wfi    (wfi_strobe),
        .armed  (!mode.cpu_keep),
        .wake   (wake),
        .halted (halted)
    );

    assign cpu_clk_en     = !halted;
    assign addr_strobe_en = !halted;
    assign ct0_run        = run_v[IDX_CT0];
    assign ct1_run        = run_v[IDX_CT1];
    assign uart_run       = run_v[IDX_UART];
    assign ct0_irq_out    = irq_gate_v[IDX_CT0];
    assign ct1_irq_out    = irq_gate_v[IDX_CT1];
    assign uart_irq_out   = irq_gate_v[IDX_UART];
endmodule

// File: rtl/hpc_checker.sv
module hpc_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] cfg_rdata,
    input logic       wfi_strobe,
    input logic       cascade_en,
    input logic       wake_ext,
    input logic       uart_irq_raw,
    input logic       ct0_irq_raw,
    input logic       ct1_irq_raw,
    input logic       cpu_clk_en,
    input logic       addr_strobe_en,
    input logic       uart_run,
    input logic       ct0_run,
    input logic       ct1_run,
    input logic       uart_irq_out
);
    logic any_src;
    assign any_src = wake_ext || uart_irq_raw || ct0_irq_raw || ct1_irq_raw;

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[7:4] == 4'h0);

    a_r3_enter_halt: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en && wfi_strobe && !cfg_rdata[3] && !any_src
        |=> !cpu_clk_en && !addr_strobe_en);

    a_r4_not_armed: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en && wfi_strobe && cfg_rdata[3] |=> cpu_clk_en);

    a_r5_wake_blocks: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en && any_src |=> cpu_clk_en);

    a_r6_run_all: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |-> uart_run && ct0_run && ct1_run);

    a_r7_uart_gate: assert property (@(posedge clk) disable iff (rst)
        !cpu_clk_en |-> (uart_run == cfg_rdata[2]) && (uart_irq_out == (uart_irq_raw && cfg_rdata[2])));

    a_r9_cascade: assert property (@(posedge clk) disable iff (rst)
        !cpu_clk_en && cascade_en |-> ct0_run == ct1_run);

    a_r10_wake: assert property (@(posedge clk) disable iff (rst)
        !cpu_clk_en && wake_ext |=> cpu_clk_en);
endmodule

bind halt_power_ctrl hpc_checker i_chk (.*);

// File: tb/test_halt_power_ctrl.sv
module test_halt_power_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       wfi_strobe = 1'b0, cascade_en = 1'b0, wake_ext = 1'b0;
    logic       uart_irq_raw = 1'b0, ct0_irq_raw = 1'b0, ct1_irq_raw = 1'b0;
    logic       cpu_clk_en, addr_strobe_en, uart_run, ct0_run, ct1_run;
    logic       uart_irq_out, ct0_irq_out, ct1_irq_out;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    halt_power_ctrl i_halt_power_ctrl (.*);

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic enter_halt(logic [7:0] m);
        wr(m);
        wfi_strobe = 1'b1;
        step();
        wfi_strobe = 1'b0;
    endtask

    task automatic leave_halt();
        wake_ext = 1'b1;
        step();
        wake_ext = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rdata", cfg_rdata, 8'h0F);
        chk("R1 clk_en", {6'd0, cpu_clk_en, addr_strobe_en}, 8'h03);
        chk("R1 runs", {5'd0, uart_run, ct1_run, ct0_run}, 8'h07);
    endtask

    task automatic t_write();
        wr(8'hF5);
        chk("R2 readback", cfg_rdata, 8'h05);
        wr(8'h3A);
        chk("R2 readback2", cfg_rdata, 8'h0A);
    endtask

    task automatic t_not_armed();
        wr(8'h08);
        wfi_strobe = 1'b1;
        step();
        wfi_strobe = 1'b0;
        chk("R4 stays running", {7'd0, cpu_clk_en}, 8'h01);
        chk("R6 runs while running", {5'd0, uart_run, ct1_run, ct0_run}, 8'h07);
    endtask

    task automatic t_run_passthru();
        wr(8'h00);
        uart_irq_raw = 1'b1; ct0_irq_raw = 1'b1; ct1_irq_raw = 1'b1;
        #1;
        chk("R6 irq pass", {5'd0, uart_irq_out, ct1_irq_out, ct0_irq_out}, 8'h07);
        uart_irq_raw = 1'b0; ct0_irq_raw = 1'b0; ct1_irq_raw = 1'b0;
    endtask

    task automatic t_enter();
        enter_halt(8'h00);
        chk("R3 halted", {6'd0, cpu_clk_en, addr_strobe_en}, 8'h00);
        chk("R7 R8 R9 all stopped", {5'd0, uart_run, ct1_run, ct0_run}, 8'h00);
        uart_irq_raw = 1'b1; ct0_irq_raw = 1'b1; ct1_irq_raw = 1'b1;
        #1;
        chk("R7 R8 irq blocked", {5'd0, uart_irq_out, ct1_irq_out, ct0_irq_out}, 8'h00);
        step();
        chk("R11 stopped irq no wake", {7'd0, cpu_clk_en}, 8'h00);
        uart_irq_raw = 1'b0; ct0_irq_raw = 1'b0; ct1_irq_raw = 1'b0;
        leave_halt();
        chk("R10 wake resumes", {6'd0, cpu_clk_en, addr_strobe_en}, 8'h03);
    endtask

    task automatic t_same_cycle();
        wr(8'h00);
        wfi_strobe = 1'b1; wake_ext = 1'b1;
        step();
        wfi_strobe = 1'b0; wake_ext = 1'b0;
        chk("R5 wake_ext blocks", {7'd0, cpu_clk_en}, 8'h01);
        wfi_strobe = 1'b1; ct1_irq_raw = 1'b1;
        step();
        wfi_strobe = 1'b0; ct1_irq_raw = 1'b0;
        chk("R5 irq blocks", {7'd0, cpu_clk_en}, 8'h01);
    endtask

    task automatic t_uart_keep();
        enter_halt(8'h04);
        chk("R7 uart kept", {5'd0, uart_run, ct1_run, ct0_run}, 8'h04);
        ct0_irq_raw = 1'b1;
        step();
        chk("R11 ct0 stopped no wake", {7'd0, cpu_clk_en}, 8'h00);
        ct0_irq_raw = 1'b0;
        uart_irq_raw = 1'b1;
        #1;
        chk("R7 uart irq passes", {7'd0, uart_irq_out}, 8'h01);
        step();
        uart_irq_raw = 1'b0;
        chk("R11 uart irq wakes", {7'd0, cpu_clk_en}, 8'h01);
    endtask

    task automatic t_counters();
        cascade_en = 1'b0;
        enter_halt(8'h01);
        chk("R8 ct0 kept", {5'd0, uart_run, ct1_run, ct0_run}, 8'h01);
        ct0_irq_raw = 1'b1;
        #1;
        chk("R8 ct0 irq passes", {7'd0, ct0_irq_out}, 8'h01);
        step();
        ct0_irq_raw = 1'b0;
        chk("R11 ct0 irq wakes", {7'd0, cpu_clk_en}, 8'h01);

        cascade_en = 1'b1;
        enter_halt(8'h01);
        chk("R9 cascade ct1 bit rules", {5'd0, uart_run, ct1_run, ct0_run}, 8'h00);
        leave_halt();
        enter_halt(8'h02);
        chk("R9 cascade both run", {5'd0, uart_run, ct1_run, ct0_run}, 8'h03);
        cascade_en = 1'b0;
        #1;
        chk("R9 no cascade ct0 own bit", {5'd0, uart_run, ct1_run, ct0_run}, 8'h02);
        ct1_irq_raw = 1'b1;
        step();
        ct1_irq_raw = 1'b0;
        chk("R11 ct1 irq wakes", {7'd0, cpu_clk_en}, 8'h01);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write();
        t_not_armed();
        t_run_passthru();
        t_enter();
        t_same_cycle();
        t_uart_keep();
        t_counters();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule